// File: doc/BRIEF.md
# Vector Store Micro-op Mask Decoder

This block sits between the issue side of a vector store path and the logic that splits micro-ops into scalar memory accesses. It takes one vector store micro-op per handshake and returns the decoded view of it: which elements of this micro-op are live, how many elements it covers, which destination register group it belongs to, how wide each memory access is, whether the micro-op must be split element by element, and where its first byte lies relative to the base address.

Work is spread over two registered stages. The first stage derives the effective vector length for the store kind and builds two masks. One is the per-micro-op flow mask, a window of the source mask that starts at the first element of this micro-op. The other is the completion mask for the merge buffer, a window aligned to the destination register. Indexed stores whose index group is wider than the data group send several micro-ops to one destination register, and each gets its own slice inside it. The second stage turns the element position into a byte offset and an element stride. Each result leaving the block is one merge-buffer entry request. A redirect empties both stages.

Top module: `vsd_uop_decoder`

## Requirements
- R1: The effective length is nfields*16>>eew for whole-register stores (kind 2), ceil(vl/8) for mask stores (kind 1), and vl for unit-stride (kind 0), strided (kind 3) and indexed (kind 4) stores. eew and sew are log2 of the element size in bytes. Masks are 16 bits wide because VLEN is 128.
- R2: An element e is active when e >= vstart, e < effective length, and either vm=1 or v0 bit e is set. Whole-register and mask stores treat every element as enabled, whatever vm and v0 hold.
- R3: The per-uop element count is 16>>eew, or 16>>max(eew,sew) for indexed stores. The uop's first element is uop_idx times that count. Flow-mask bit i reports element first+i, and bits at or above the count are zero.
- R4: The destination index is uop_idx>>(emul-lmul) for indexed stores with signed emul > signed lmul, and uop_idx otherwise.
- R5: The merge count is 16>>dw, where dw is sew for indexed stores and eew otherwise. Merge-mask bit i reports element dest_index*merge_count+i. Bits at or above the merge count are zero.
- R6: The split flag is 1 for strided and indexed stores and 0 otherwise. The split count is the per-uop element count when the flag is 1, and 1 when it is 0.
- R7: The access-width code is 4 (full 16-byte access) for non-split kinds and dw for split kinds.
- R8: The byte offset is first*stride for strided stores, 0 for indexed stores, and first<<dw otherwise. The stride output is the input stride for strided stores and 1<<dw otherwise.
- R9: An accepted uop appears on the output two clock edges after its acceptance edge, and results leave in acceptance order.
- R10: While out_valid is high and out_ready is low, every output holds its value. in_ready is low only when both stages are full and the output is stalled.
- R11: A cycle with redirect_valid high removes every uop held in the block and any uop accepted in that same cycle, so out_valid is low at the next edge.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Flush both stages |
| in_valid | input | 1 | Uop offered |
| in_ready | output | 1 | Uop can be taken |
| in_kind | input | 3 | Store kind: 0 unit, 1 mask, 2 whole, 3 strided, 4 indexed |
| in_vm | input | 1 | 1 = unmasked |
| in_v0 | input | VLEN | Mask register |
| in_vstart | input | IDX_W | First element to store |
| in_vl | input | IDX_W | Vector length |
| in_eew | input | 2 | log2 bytes of data (index for indexed) element |
| in_sew | input | 2 | log2 bytes of data element for indexed stores |
| in_emul | input | 3 | Signed log2 of the register group for eew |
| in_lmul | input | 3 | Signed log2 of the register group for sew |
| in_nfields | input | NF_W | Register count for whole-register stores |
| in_uop_idx | input | UIDX_W | Uop index inside the instruction |
| in_stride | input | XLEN | Byte stride for strided stores |
| out_valid | output | 1 | Result and merge request valid |
| out_ready | input | 1 | Result taken |
| out_flow_mask | output | MASK_W | Active elements of this uop |
| out_flow_cnt | output | CNT_W | Split count |
| out_merge_mask | output | MASK_W | Active elements of the destination register |
| out_merge_cnt | output | CNT_W | Elements tracked for completion |
| out_vd_idx | output | UIDX_W | Destination register index |
| out_width | output | 3 | Access-width code |
| out_split | output | 1 | Element-wise split needed |
| out_offset | output | XLEN | Byte offset of the uop |
| out_stride | output | XLEN | Byte stride between elements |

## Verification
A wrong window start or a wrong element count in the first stage shows up as a shifted or over-wide flow or merge mask on the result two edges after acceptance. A wrong destination index shows in the same cycle. A stage whose valid bit is lost or duplicated under backpressure shows up at the ports as a missing, repeated or reordered result once out_ready returns. The same holds for a flush that misses a stage: the stale uop appears on the output one edge after the redirect. The vectors cover each store kind with vstart, vl and v0 edges, and shared destination registers for indexed stores with emul above and below lmul.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [2:0] {
        K_UNIT    = 3'd0,
        K_MASK    = 3'd1,
        K_WHOLE   = 3'd2,
        K_STRIDED = 3'd3,
        K_INDEXED = 3'd4
    } st_kind_e;

    localparam logic [2:0] WIDTH_FULL = 3'd4;

    function automatic logic kind_splits(st_kind_e k);
        return (k == K_STRIDED) || (k == K_INDEXED);
    endfunction

endpackage

// File: rtl/vsd_evl_calc.sv
module vsd_evl_calc #(
    parameter int VLEN  = 128,
    parameter int IDX_W = 8,
    parameter int NF_W  = 4
) (
    input  vsd_pkg::st_kind_e  kind,
    input  logic [IDX_W-1:0]   vl,
    input  logic [NF_W-1:0]    nfields,
    input  logic [1:0]         eew,
    output logic [IDX_W-1:0]   evl
);
    import vsd_pkg::*;

    localparam int MASK_W = VLEN / 8;
    localparam int PW     = IDX_W + NF_W;

    logic [PW-1:0]  whole_len;
    logic [IDX_W:0] byte_len;

    always_comb begin
        whole_len = (PW'(nfields) * PW'(MASK_W)) >> eew;
        byte_len  = ({1'b0, vl} + (IDX_W+1)'(7)) >> 3;
        case (kind)
            K_WHOLE: evl = IDX_W'(whole_len);
            K_MASK:  evl = IDX_W'(byte_len);
            default: evl = vl;
        endcase
    end

endmodule

// File: rtl/vsd_mask_window.sv
module vsd_mask_window #(
    parameter int VLEN  = 128,
    parameter int IDX_W = 8,
    parameter int CNT_W = 5
) (
    input  logic [IDX_W-1:0]    first,
    input  logic [CNT_W-1:0]    count,
    input  logic [IDX_W-1:0]    vstart,
    input  logic [IDX_W-1:0]    evl,
    input  logic                unmasked,
    input  logic [VLEN-1:0]     v0,
    output logic [VLEN/8-1:0]   mask
);
    localparam int MASK_W = VLEN / 8;
    localparam int SEL_W  = $clog2(VLEN);

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        logic [IDX_W:0] elem;
        logic           enabled;
        assign elem    = {1'b0, first} + (IDX_W+1)'(i);
        assign enabled = (elem < (IDX_W+1)'(VLEN)) ? v0[elem[SEL_W-1:0]] : 1'b0;
        assign mask[i] = (CNT_W'(i) < count)
                      && (elem >= {1'b0, vstart})
                      && (elem <  {1'b0, evl})
                      && (unmasked || enabled);
    end

endmodule

// File: rtl/vsd_uop_decoder.sv
module vsd_uop_decoder #(
    parameter  int VLEN   = 128,
    parameter  int UIDX_W = 3,
    parameter  int NF_W   = 4,
    parameter  int XLEN   = 32,
    localparam int MASK_W = VLEN / 8,
    localparam int IDX_W  = $clog2(VLEN) + 1,
    localparam int CNT_W  = $clog2(MASK_W) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    redirect_valid,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [2:0]              in_kind,
    input  logic                    in_vm,
    input  logic [VLEN-1:0]         in_v0,
    input  logic [IDX_W-1:0]        in_vstart,
    input  logic [IDX_W-1:0]        in_vl,
    input  logic [1:0]              in_eew,
    input  logic [1:0]              in_sew,
    input  logic signed [2:0]       in_emul,
    input  logic signed [2:0]       in_lmul,
    input  logic [NF_W-1:0]         in_nfields,
    input  logic [UIDX_W-1:0]       in_uop_idx,
    input  logic [XLEN-1:0]         in_stride,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [MASK_W-1:0]       out_flow_mask,
    output logic [CNT_W-1:0]        out_flow_cnt,
    output logic [MASK_W-1:0]       out_merge_mask,
    output logic [CNT_W-1:0]        out_merge_cnt,
    output logic [UIDX_W-1:0]       out_vd_idx,
    output logic [2:0]              out_width,
    output logic                    out_split,
    output logic [XLEN-1:0]         out_offset,
    output logic [XLEN-1:0]         out_stride
);
    import vsd_pkg::*;

    typedef struct packed {
        logic                valid;
        st_kind_e            kind;
        logic                split;
        logic [1:0]          dw;
        logic [2:0]          width;
        logic [IDX_W-1:0]    first;
        logic [UIDX_W-1:0]   vd;
        logic [MASK_W-1:0]   fmask;
        logic [CNT_W-1:0]    fcnt;
        logic [MASK_W-1:0]   mmask;
        logic [CNT_W-1:0]    mcnt;
        logic [XLEN-1:0]     stride;
    } dec_t;

    typedef struct packed {
        logic                valid;
        logic [MASK_W-1:0]   fmask;
        logic [CNT_W-1:0]    fcnt;
        logic [MASK_W-1:0]   mmask;
        logic [CNT_W-1:0]    mcnt;
        logic [UIDX_W-1:0]   vd;
        logic [2:0]          width;
        logic                split;
        logic [XLEN-1:0]     offset;
        logic [XLEN-1:0]     stride;
    } res_t;

    typedef struct packed {
        dec_t s0;
        res_t s1;
    } pipe_t;

    pipe_t st_d, st_q;

    // First-stage decode of the offered uop
    st_kind_e          kind_d;
    logic              indexed_d, shared_d, unmasked_d;
    logic [1:0]        dw_d, fw_d;
    logic [2:0]        grp_shift_d;
    logic [CNT_W-1:0]  flows_d, per_vd_d;
    logic [UIDX_W-1:0] vd_d;
    logic [IDX_W-1:0]  first_d, vd_first_d, evl_d;
    logic [MASK_W-1:0] fmask_d, mmask_d;

    always_comb begin
        kind_d      = st_kind_e'(in_kind);
        indexed_d   = (kind_d == K_INDEXED);
        dw_d        = indexed_d ? in_sew : in_eew;
        fw_d        = (indexed_d && (in_sew > in_eew)) ? in_sew : in_eew;
        flows_d     = CNT_W'(MASK_W) >> fw_d;
        per_vd_d    = CNT_W'(MASK_W) >> dw_d;
        shared_d    = indexed_d && (in_emul > in_lmul);
        grp_shift_d = in_emul - in_lmul;
        vd_d        = shared_d ? (in_uop_idx >> grp_shift_d) : in_uop_idx;
        first_d     = IDX_W'(in_uop_idx) * IDX_W'(flows_d);
        vd_first_d  = IDX_W'(vd_d) * IDX_W'(per_vd_d);
        unmasked_d  = in_vm || (kind_d == K_MASK) || (kind_d == K_WHOLE);
    end

    vsd_evl_calc #(.VLEN(VLEN), .IDX_W(IDX_W), .NF_W(NF_W)) u_evl (
        .kind    (kind_d),
        .vl      (in_vl),
        .nfields (in_nfields),
        .eew     (in_eew),
        .evl     (evl_d)
    );

    vsd_mask_window #(.VLEN(VLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_flow_win (
        .first    (first_d),
        .count    (flows_d),
        .vstart   (in_vstart),
        .evl      (evl_d),
        .unmasked (unmasked_d),
        .v0       (in_v0),
        .mask     (fmask_d)
    );

    vsd_mask_window #(.VLEN(VLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_merge_win (
        .first    (vd_first_d),
        .count    (per_vd_d),
        .vstart   (in_vstart),
        .evl      (evl_d),
        .unmasked (unmasked_d),
        .v0       (in_v0),
        .mask     (mmask_d)
    );

    // Handshake
    logic s1_free, s0_free;
    assign s1_free  = !st_q.s1.valid || out_ready;
    assign s0_free  = !st_q.s0.valid || s1_free;
    assign in_ready = s0_free;

    always_comb begin
        st_d = st_q;
        if (s1_free) begin
            st_d.s1.valid = st_q.s0.valid;
            if (st_q.s0.valid) begin
                st_d.s1.fmask = st_q.s0.fmask;
                st_d.s1.fcnt  = st_q.s0.fcnt;
                st_d.s1.mmask = st_q.s0.mmask;
                st_d.s1.mcnt  = st_q.s0.mcnt;
                st_d.s1.vd    = st_q.s0.vd;
                st_d.s1.width = st_q.s0.width;
                st_d.s1.split = st_q.s0.split;
                case (st_q.s0.kind)
                    K_STRIDED: begin
                        st_d.s1.offset = XLEN'(st_q.s0.first) * st_q.s0.stride;
                        st_d.s1.stride = st_q.s0.stride;
                    end
                    K_INDEXED: begin
                        st_d.s1.offset = '0;
                        st_d.s1.stride = XLEN'(1) << st_q.s0.dw;
                    end
                    default: begin
                        st_d.s1.offset = XLEN'(st_q.s0.first) << st_q.s0.dw;
                        st_d.s1.stride = XLEN'(1) << st_q.s0.dw;
                    end
                endcase
            end
        end
        if (s0_free) begin
            st_d.s0.valid = in_valid;
            if (in_valid) begin
                st_d.s0.kind   = kind_d;
                st_d.s0.split  = kind_splits(kind_d);
                st_d.s0.dw     = dw_d;
                st_d.s0.width  = kind_splits(kind_d) ? {1'b0, dw_d} : WIDTH_FULL;
                st_d.s0.first  = first_d;
                st_d.s0.vd     = vd_d;
                st_d.s0.fmask  = fmask_d;
                st_d.s0.fcnt   = kind_splits(kind_d) ? flows_d : CNT_W'(1);
                st_d.s0.mmask  = mmask_d;
                st_d.s0.mcnt   = per_vd_d;
                st_d.s0.stride = in_stride;
            end
        end
        if (redirect_valid) begin
            st_d.s0.valid = 1'b0;
            st_d.s1.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.s1.valid;
    assign out_flow_mask  = st_q.s1.fmask;
    assign out_flow_cnt   = st_q.s1.fcnt;
    assign out_merge_mask = st_q.s1.mmask;
    assign out_merge_cnt  = st_q.s1.mcnt;
    assign out_vd_idx     = st_q.s1.vd;
    assign out_width      = st_q.s1.width;
    assign out_split      = st_q.s1.split;
    assign out_offset     = st_q.s1.offset;
    assign out_stride     = st_q.s1.stride;

    // Stalled result stays put (R10)
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !redirect_valid |=>
            out_valid && $stable(out_flow_mask) && $stable(out_merge_mask)
            && $stable(out_offset) && $stable(out_vd_idx));

    // Input only blocked by a stalled, full pipe (R10)
    p_stall_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready);

    // Redirect empties the block (R11)
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !out_valid);

    // Flow mask never wider than the split count (R3)
    p_flow_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_split |-> $countones(out_flow_mask) <= int'(out_flow_cnt));

    // Merge mask confined to the register window (R5)
    p_merge_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_merge_mask >> out_merge_cnt) == '0);

    // Width code agrees with the split flag (R7)
    p_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_split == (out_width != WIDTH_FULL)));

endmodule

// File: tb/vsd_uop_decoder_tb.sv
module vsd_uop_decoder_tb;

    typedef struct packed {
        logic [2:0]        kind;
        logic              vm;
        logic [15:0]       v0;
        logic [7:0]        vstart;
        logic [7:0]        vl;
        logic [1:0]        eew;
        logic [1:0]        sew;
        logic signed [2:0] emul;
        logic signed [2:0] lmul;
        logic [3:0]        nf;
        logic [2:0]        uidx;
        logic [31:0]       stride;
        logic [15:0]       fmask;
        logic [15:0]       mmask;
        logic [4:0]        fcnt;
        logic [4:0]        mcnt;
        logic [2:0]        vd;
        logic [2:0]        width;
        logic              split;
        logic [31:0]       offset;
        logic [31:0]       ostride;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        // indexed, shared destination, first and second uop
        '{3'd4, 1'b0, 16'h01FF, 8'd0, 8'd9, 2'd1, 2'd0, 3'sd1, 3'sd0, 4'd1, 3'd0, 32'd0,
          16'h00FF, 16'h01FF, 5'd8, 5'd16, 3'd0, 3'd0, 1'b1, 32'd0, 32'd1},
        '{3'd4, 1'b0, 16'h01FF, 8'd0, 8'd9, 2'd1, 2'd0, 3'sd1, 3'sd0, 4'd1, 3'd1, 32'd0,
          16'h0001, 16'h01FF, 5'd8, 5'd16, 3'd0, 3'd0, 1'b1, 32'd0, 32'd1},
        // unit-stride, vl limit
        '{3'd0, 1'b1, 16'h0000, 8'd0, 8'd5, 2'd0, 2'd0, 3'sd0, 3'sd0, 4'd1, 3'd0, 32'd0,
          16'h001F, 16'h001F, 5'd1, 5'd16, 3'd0, 3'd4, 1'b0, 32'd0, 32'd1},
        // unit-stride e16 second uop, vstart and v0
        '{3'd0, 1'b0, 16'h0F00, 8'd9, 8'd12, 2'd1, 2'd1, 3'sd1, 3'sd1, 4'd1, 3'd1, 32'd0,
          16'h000E, 16'h000E, 5'd1, 5'd8, 3'd1, 3'd4, 1'b0, 32'd16, 32'd2},
        // mask store: ceil(20/8)=3, v0 ignored
        '{3'd1, 1'b0, 16'h0000, 8'd0, 8'd20, 2'd0, 2'd0, 3'sd0, 3'sd0, 4'd1, 3'd0, 32'd0,
          16'h0007, 16'h0007, 5'd1, 5'd16, 3'd0, 3'd4, 1'b0, 32'd0, 32'd1},
        // whole, nf=2 e32: evl=8, vl ignored
        '{3'd2, 1'b0, 16'h0000, 8'd0, 8'd3, 2'd2, 2'd2, 3'sd0, 3'sd0, 4'd2, 3'd1, 32'd0,
          16'h000F, 16'h000F, 5'd1, 5'd4, 3'd1, 3'd4, 1'b0, 32'd16, 32'd4},
        // whole, nf=1 e8: evl=16
        '{3'd2, 1'b0, 16'h0000, 8'd0, 8'd0, 2'd0, 2'd0, 3'sd0, 3'sd0, 4'd1, 3'd0, 32'd0,
          16'hFFFF, 16'hFFFF, 5'd1, 5'd16, 3'd0, 3'd4, 1'b0, 32'd0, 32'd1},
        // strided e32 third uop
        '{3'd3, 1'b0, 16'h0A00, 8'd0, 8'd16, 2'd2, 2'd2, 3'sd2, 3'sd2, 4'd1, 3'd2, 32'd12,
          16'h000A, 16'h000A, 5'd4, 5'd4, 3'd2, 3'd2, 1'b1, 32'd96, 32'd12},
        // strided, vstart == vl: nothing active
        '{3'd3, 1'b1, 16'h0000, 8'd16, 8'd16, 2'd0, 2'd0, 3'sd0, 3'sd0, 4'd1, 3'd0, 32'd3,
          16'h0000, 16'h0000, 5'd16, 5'd16, 3'd0, 3'd0, 1'b1, 32'd0, 32'd3},
        // indexed, emul < lmul: one register per uop
        '{3'd4, 1'b1, 16'h0000, 8'd0, 8'd14, 2'd0, 2'd2, 3'sd0, 3'sd1, 4'd1, 3'd3, 32'd0,
          16'h0003, 16'h0003, 5'd4, 5'd4, 3'd3, 3'd2, 1'b1, 32'd0, 32'd4},
        // indexed, ratio 8: uop 5 lands in register 0
        '{3'd4, 1'b1, 16'h0000, 8'd0, 8'd22, 2'd2, 2'd0, 3'sd3, 3'sd0, 4'd1, 3'd5, 32'd0,
          16'h0003, 16'hFFFF, 5'd4, 5'd16, 3'd0, 3'd0, 1'b1, 32'd0, 32'd1},
        // strided with emul > lmul keeps vd = uop index
        '{3'd3, 1'b1, 16'h0000, 8'd0, 8'd20, 2'd0, 2'd0, 3'sd1, 3'sd0, 4'd1, 3'd1, 32'd2,
          16'h000F, 16'h000F, 5'd16, 5'd16, 3'd1, 3'd0, 1'b1, 32'd32, 32'd2}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               redirect_valid;
    logic               in_valid;
    logic               in_ready;
    logic [2:0]         in_kind;
    logic               in_vm;
    logic [127:0]       in_v0;
    logic [7:0]         in_vstart;
    logic [7:0]         in_vl;
    logic [1:0]         in_eew;
    logic [1:0]         in_sew;
    logic signed [2:0]  in_emul;
    logic signed [2:0]  in_lmul;
    logic [3:0]         in_nfields;
    logic [2:0]         in_uop_idx;
    logic [31:0]        in_stride;
    logic               out_valid;
    logic               out_ready;
    logic [15:0]        out_flow_mask;
    logic [4:0]         out_flow_cnt;
    logic [15:0]        out_merge_mask;
    logic [4:0]         out_merge_cnt;
    logic [2:0]         out_vd_idx;
    logic [2:0]         out_width;
    logic               out_split;
    logic [31:0]        out_offset;
    logic [31:0]        out_stride;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    vsd_uop_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_vm(in_vm),
        .in_v0(in_v0), .in_vstart(in_vstart), .in_vl(in_vl), .in_eew(in_eew),
        .in_sew(in_sew), .in_emul(in_emul), .in_lmul(in_lmul), .in_nfields(in_nfields),
        .in_uop_idx(in_uop_idx), .in_stride(in_stride),
        .out_valid(out_valid), .out_ready(out_ready), .out_flow_mask(out_flow_mask),
        .out_flow_cnt(out_flow_cnt), .out_merge_mask(out_merge_mask),
        .out_merge_cnt(out_merge_cnt), .out_vd_idx(out_vd_idx), .out_width(out_width),
        .out_split(out_split), .out_offset(out_offset), .out_stride(out_stride)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_kind    = v.kind;
        in_vm      = v.vm;
        in_v0      = {112'd0, v.v0};
        in_vstart  = v.vstart;
        in_vl      = v.vl;
        in_eew     = v.eew;
        in_sew     = v.sew;
        in_emul    = v.emul;
        in_lmul    = v.lmul;
        in_nfields = v.nf;
        in_uop_idx = v.uidx;
        in_stride  = v.stride;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; redirect_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R12 in_ready after reset", 64'(in_ready), 64'd1);

        // Table walk: one uop at a time, output taken at once
        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k]);
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R9 vec%0d not yet valid", k), 64'(out_valid), 64'd0);
            @(negedge clk);
            chk($sformatf("R9 vec%0d valid after two edges", k), 64'(out_valid), 64'd1);
            chk($sformatf("R3 vec%0d flow mask (R1/R2)", k), 64'(out_flow_mask), 64'(VECS[k].fmask));
            chk($sformatf("R5 vec%0d merge mask", k), 64'(out_merge_mask), 64'(VECS[k].mmask));
            chk($sformatf("R5 vec%0d merge count", k), 64'(out_merge_cnt), 64'(VECS[k].mcnt));
            chk($sformatf("R6 vec%0d split count", k), 64'(out_flow_cnt), 64'(VECS[k].fcnt));
            chk($sformatf("R6 vec%0d split flag", k), 64'(out_split), 64'(VECS[k].split));
            chk($sformatf("R4 vec%0d vd index", k), 64'(out_vd_idx), 64'(VECS[k].vd));
            chk($sformatf("R7 vec%0d width code", k), 64'(out_width), 64'(VECS[k].width));
            chk($sformatf("R8 vec%0d offset", k), 64'(out_offset), 64'(VECS[k].offset));
            chk($sformatf("R8 vec%0d stride", k), 64'(out_stride), 64'(VECS[k].ostride));
        end
        @(negedge clk);

        // R10: backpressure with three uops, order kept
        out_ready = 1'b0;
        drive(VECS[0]); in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        drive(VECS[1]);
        @(posedge clk); @(negedge clk);
        drive(VECS[2]);
        @(posedge clk); @(negedge clk);
        chk("R10 in_ready low when full", 64'(in_ready), 64'd0);
        chk("R10 stalled output valid", 64'(out_valid), 64'd1);
        chk("R10 stalled output is first uop", 64'(out_flow_mask), 64'h00FF);
        repeat (3) @(negedge clk);
        chk("R10 output held", 64'(out_flow_mask), 64'h00FF);
        chk("R10 still blocked", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk("R9 second uop in order", 64'(out_flow_mask), 64'h0001);
        @(negedge clk);
        chk("R9 third uop in order", 64'(out_flow_mask), 64'h001F);
        chk("R9 third uop valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R9 pipe drained", 64'(out_valid), 64'd0);

        // R11: redirect flushes both full stages
        out_ready = 1'b0;
        drive(VECS[3]); in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        drive(VECS[4]);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk("R11 pipe full before redirect", 64'(out_valid), 64'd1);
        redirect_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        redirect_valid = 1'b0;
        chk("R11 output empty after redirect", 64'(out_valid), 64'd0);
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 no stale uop appears", 64'(out_valid), 64'd0);

        // R11: uop accepted in the redirect cycle is dropped
        drive(VECS[5]); in_valid = 1'b1; redirect_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; redirect_valid = 1'b0;
        begin
            logic seen = 1'b0;
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                if (out_valid) seen = 1'b1;
            end
            chk("R11 same-cycle uop dropped", 64'(seen), 64'd0);
        end

        // Recovery after redirect
        drive(VECS[6]); in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 valid after recovery", 64'(out_valid), 64'd1);
        chk("R1 whole store after recovery", 64'(out_flow_mask), 64'hFFFF);
        @(negedge clk);

        finish_run();
    end

endmodule